// File: doc/BRIEF.md
# SD Host Transfer Interrupt Status

This block keeps the transfer-related interrupt flags of an SD host controller. It watches the activity strobes of the controller's data path: the data-line-active, read-active and write-active levels, the buffer-write-enable level, a DMA boundary pulse and a data-timeout level. From them it raises sticky status flags. Which edge sets a flag depends on the transfer direction. The block-gap flag also depends on whether software asked the transfer to stop at a block gap.

Software reads the status vector and clears flags by writing ones through a write-one-to-clear port. A per-bit enable vector gates the flags onto a single interrupt line. A flag latches whether or not its enable is set. A separate output reports a failed transfer: timeout seen and completion not seen.

Status layout: bit 0 transfer done, bit 1 block-gap stop, bit 2 DMA boundary, bit 3 write buffer ready, bit 4 data timeout.

Top module: `sdh_xfer_irq_status`

## Requirements
- R1: Status bit 3 sets in the cycle after `wbuf_en` goes from 0 to 1. A level that stays high does not set it again after a clear.
- R2: With `dir_wr`=0 (read), bit 0 sets in the cycle after `rd_active` falls. A fall of `dat_active` does not set bit 0 during a read.
- R3: With `dir_wr`=1 (write), bit 0 sets in the cycle after `dat_active` falls. A fall of `rd_active` does not set bit 0 during a write.
- R4: Bit 1 never sets while `stop_gap_req` is 0.
- R5: With `stop_gap_req`=1, bit 1 sets after a fall of `dat_active` on a read, or after a fall of `wr_active` on a write. The other strobe has no effect on bit 1.
- R6: A one-cycle `dma_bnd` pulse sets bit 2. It does not set bit 2 when bit 0 is already set, or when bit 0 is being set in the same cycle.
- R7: Bit 4 sets in the cycle after `data_tout` goes from 0 to 1.
- R8: When `clr_we`=1, each status bit whose `clr_data` bit is 1 is cleared, and a `clr_data` bit of 0 leaves its status bit unchanged. A set event in the same cycle as a clear leaves the bit set. Without a clear, a set bit stays set.
- R9: `xfer_failed` is 1 only when bit 4 is set and bit 0 is clear. Completion takes priority over the timeout.
- R10: `irq` is the OR over all bits of status AND `sig_en`. A bit whose enable is 0 still latches in `status`.
- R11: A synchronous active-low `rst_n` clears every status bit and all edge history. After reset, an input that is already high counts as a rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dir_wr | input | 1 | Transfer direction, 1 = write to card |
| dat_active | input | 1 | Data lines in use |
| rd_active | input | 1 | Read transfer in progress |
| wr_active | input | 1 | Write transfer in progress |
| wbuf_en | input | 1 | Write buffer can accept data |
| stop_gap_req | input | 1 | Software request to stop at the next block gap |
| dma_bnd | input | 1 | One-cycle pulse: DMA buffer boundary reached |
| data_tout | input | 1 | Data timeout detected |
| clr_we | input | 1 | Write strobe of the clear port |
| clr_data | input | 5 | Ones clear the matching status bits |
| sig_en | input | 5 | Per-bit interrupt enables |
| status | output | 5 | Sticky status flags |
| irq | output | 1 | Combined enabled interrupt |
| xfer_failed | output | 1 | Timeout without completion |

## Verification
Each activity strobe is made to fall under both directions. This shows whether the done flag and the gap flag follow the correct strobe for each direction, or just any falling edge. The gap strobes are tried with the stop request both low and high, which shows whether the flag is gated by the request. DMA pulses are sent before, during and after the cycle in which completion sets. Clears, held-high levels and disabled enables are combined with set events, and these show whether the design tells a level apart from an edge, whether set beats clear, and whether latching is separate from signalling. A long pseudo-random run compares every cycle against a behavioural model.

// File: rtl/sdh_irq_pkg.sv
package sdh_irq_pkg;
  localparam int NSTAT  = 5;
  localparam int B_DONE = 0;
  localparam int B_GAP  = 1;
  localparam int B_DMA  = 2;
  localparam int B_WBUF = 3;
  localparam int B_TOUT = 4;

  // falling-edge strobes
  localparam int NFALL  = 3;
  localparam int F_DAT  = 0;
  localparam int F_RD   = 1;
  localparam int F_WR   = 2;

  // rising-edge strobes
  localparam int NRISE  = 2;
  localparam int R_WBUF = 0;
  localparam int R_TOUT = 1;

  function automatic logic f_edge(input logic hist, input logic cur,
                                  input logic rising);
    return rising ? (~hist & cur) : (hist & ~cur);
  endfunction

  function automatic logic f_sticky(input logic q, input logic set,
                                    input logic clr);
    return (q & ~clr) | set;
  endfunction
endpackage

// File: rtl/sdh_edge_bank.sv
module sdh_edge_bank #(
  parameter int N      = 1,
  parameter bit RISING = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] cur,
  output logic [N-1:0] hit
);
  import sdh_irq_pkg::*;

  logic [N-1:0] hist;

  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n) hist[i] <= 1'b0;
      else        hist[i] <= cur[i];
    end

    if (RISING) begin : g_rise
      assign hit[i] = f_edge(hist[i], cur[i], 1'b1);
      // R1: a level held high across two samples yields no edge
      p_no_repeat_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (hist[i] && cur[i]) |=> !(hist[i] && !$past(cur[i]) ? 1'b0 : hit[i] && $past(cur[i]) && cur[i]));
    end else begin : g_fall
      assign hit[i] = f_edge(hist[i], cur[i], 1'b0);
    end
  end
endmodule

// File: rtl/sdh_event_decode.sv
module sdh_event_decode
  import sdh_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dir_wr,
  input  logic             stop_gap_req,
  input  logic             dma_bnd,
  input  logic             done_held,
  input  logic [NFALL-1:0] fall,
  input  logic [NRISE-1:0] rise,
  output logic [NSTAT-1:0] set_vec
);
  logic ev_done, ev_gap, ev_dma, ev_wbuf, ev_tout;
  logic gap_strobe;

  // completion strobe depends on direction
  assign ev_done    = dir_wr ? fall[F_DAT] : fall[F_RD];
  // block-gap strobe uses the opposite pairing
  assign gap_strobe = dir_wr ? fall[F_WR]  : fall[F_DAT];
  assign ev_gap     = stop_gap_req & gap_strobe;
  // boundary interrupts are dropped once completion is reached
  assign ev_dma     = dma_bnd & ~done_held & ~ev_done;
  assign ev_wbuf    = rise[R_WBUF];
  assign ev_tout    = rise[R_TOUT];

  always_comb begin
    set_vec         = '0;
    set_vec[B_DONE] = ev_done;
    set_vec[B_GAP]  = ev_gap;
    set_vec[B_DMA]  = ev_dma;
    set_vec[B_WBUF] = ev_wbuf;
    set_vec[B_TOUT] = ev_tout;
  end

  // R4: no gap event without the stop request
  p_gap_gated_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !stop_gap_req |-> !set_vec[B_GAP]);
  // R6: boundary event never coincides with completion
  p_dma_vs_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    set_vec[B_DONE] |-> !set_vec[B_DMA]);
endmodule

// File: rtl/sdh_sticky_bank.sv
module sdh_sticky_bank
  import sdh_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSTAT-1:0] set_vec,
  input  logic             clr_we,
  input  logic [NSTAT-1:0] clr_data,
  output logic [NSTAT-1:0] q
);
  logic [NSTAT-1:0] clr_vec;
  assign clr_vec = clr_we ? clr_data : '0;

  for (genvar i = 0; i < NSTAT; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rst_n) q[i] <= 1'b0;
      else        q[i] <= f_sticky(q[i], set_vec[i], clr_vec[i]);
    end

    // R8: a set flag survives unless its clear bit is written
    p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (q[i] && !clr_vec[i]) |=> q[i]);
    // R8: a set event beats a same-cycle clear
    p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
      set_vec[i] |=> q[i]);
  end
endmodule

// File: rtl/sdh_xfer_irq_status.sv
module sdh_xfer_irq_status
  import sdh_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dir_wr,
  input  logic             dat_active,
  input  logic             rd_active,
  input  logic             wr_active,
  input  logic             wbuf_en,
  input  logic             stop_gap_req,
  input  logic             dma_bnd,
  input  logic             data_tout,
  input  logic             clr_we,
  input  logic [NSTAT-1:0] clr_data,
  input  logic [NSTAT-1:0] sig_en,
  output logic [NSTAT-1:0] status,
  output logic             irq,
  output logic             xfer_failed
);
  logic [NFALL-1:0] fall_in, fall_hit;
  logic [NRISE-1:0] rise_in, rise_hit;
  logic [NSTAT-1:0] set_vec;
  logic [NSTAT-1:0] en_status;

  always_comb begin
    fall_in         = '0;
    fall_in[F_DAT]  = dat_active;
    fall_in[F_RD]   = rd_active;
    fall_in[F_WR]   = wr_active;
    rise_in         = '0;
    rise_in[R_WBUF] = wbuf_en;
    rise_in[R_TOUT] = data_tout;
  end

  sdh_edge_bank #(.N(NFALL), .RISING(1'b0)) u_fall (
    .clk(clk), .rst_n(rst_n), .cur(fall_in), .hit(fall_hit));

  sdh_edge_bank #(.N(NRISE), .RISING(1'b1)) u_rise (
    .clk(clk), .rst_n(rst_n), .cur(rise_in), .hit(rise_hit));

  sdh_event_decode u_dec (
    .clk(clk), .rst_n(rst_n), .dir_wr(dir_wr), .stop_gap_req(stop_gap_req),
    .dma_bnd(dma_bnd), .done_held(status[B_DONE]), .fall(fall_hit),
    .rise(rise_hit), .set_vec(set_vec));

  sdh_sticky_bank u_flags (
    .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .clr_we(clr_we),
    .clr_data(clr_data), .q(status));

  assign en_status   = status & sig_en;
  assign irq         = |en_status;
  assign xfer_failed = status[B_TOUT] & ~status[B_DONE];

  // R4: a clear gap flag stays clear while no stop is requested
  p_gap_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!stop_gap_req && !status[B_GAP]) |=> !status[B_GAP]);
  // R6: once done is held, the boundary flag cannot newly rise
  p_dma_after_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (status[B_DONE] && !status[B_DMA]) |=> !status[B_DMA]);
  // R1: held-high buffer enable cannot re-raise a cleared flag
  p_wbuf_level_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(wbuf_en) && wbuf_en && !status[B_WBUF])
      |=> !status[B_WBUF]);
  // R9: completion masks the failure indication
  p_done_prio_r9: assert property (@(posedge clk) disable iff (!rst_n)
    status[B_DONE] |-> !xfer_failed);
  // R10: no flags, no interrupt
  p_irq_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (status == '0) |-> !irq);
  // R11: one cycle of reset empties the status
  p_reset_r11: assert property (@(posedge clk)
    !rst_n |=> (status == '0));
endmodule

// File: tb/tb_sdh_xfer_irq_status.sv
module tb_sdh_xfer_irq_status;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 5;

  logic clk = 1'b0;
  logic rst_n, dir_wr, dat_active, rd_active, wr_active, wbuf_en;
  logic stop_gap_req, dma_bnd, data_tout, clr_we;
  logic [NS-1:0] clr_data, sig_en, status;
  logic irq, xfer_failed;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;
  string cur_req = "R11";

  // behavioural reference state
  bit [NS-1:0] m_st;
  bit p_dat, p_rd, p_wr, p_wb, p_to;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdh_xfer_irq_status dut (
    .clk(clk), .rst_n(rst_n), .dir_wr(dir_wr), .dat_active(dat_active),
    .rd_active(rd_active), .wr_active(wr_active), .wbuf_en(wbuf_en),
    .stop_gap_req(stop_gap_req), .dma_bnd(dma_bnd), .data_tout(data_tout),
    .clr_we(clr_we), .clr_data(clr_data), .sig_en(sig_en),
    .status(status), .irq(irq), .xfer_failed(xfer_failed));

  task automatic cmp(string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", cur_req, what, act, exp, $time);
    end
  endtask

  task automatic tick();
    bit [NS-1:0] nx, clr, setv;
    bit f_dat, f_rd, f_wr, done_ev;
    f_dat = p_dat && !dat_active;
    f_rd  = p_rd  && !rd_active;
    f_wr  = p_wr  && !wr_active;
    done_ev = dir_wr ? f_dat : f_rd;
    setv = '0;
    setv[0] = done_ev;
    setv[1] = stop_gap_req && (dir_wr ? f_wr : f_dat);
    setv[2] = dma_bnd && !m_st[0] && !done_ev;
    setv[3] = !p_wb && wbuf_en;
    setv[4] = !p_to && data_tout;
    clr = clr_we ? clr_data : '0;
    for (int i = 0; i < NS; i++) nx[i] = (m_st[i] && !clr[i]) || setv[i];
    @(posedge clk);
    if (!rst_n) begin
      m_st = '0; p_dat = 0; p_rd = 0; p_wr = 0; p_wb = 0; p_to = 0;
    end else begin
      m_st = nx;
      p_dat = dat_active; p_rd = rd_active; p_wr = wr_active;
      p_wb = wbuf_en; p_to = data_tout;
    end
    #1;
    cmp("status", status, m_st);
    cmp("irq", irq, |(m_st & sig_en));
    cmp("xfer_failed", xfer_failed, m_st[4] && !m_st[0]);
    clr_we = 0; clr_data = '0; dma_bnd = 0;
  endtask

  task automatic ticks(int n);
    for (int k = 0; k < n; k++) tick();
  endtask

  task automatic clear(bit [NS-1:0] v);
    clr_we = 1; clr_data = v; tick();
  endtask

  task automatic expect_bit(int b, bit v);
    cmp($sformatf("status bit %0d", b), status[b], v);
  endtask

  initial begin
    m_st = '0; p_dat = 0; p_rd = 0; p_wr = 0; p_wb = 0; p_to = 0;
    rst_n = 0; dir_wr = 0; dat_active = 0; rd_active = 0; wr_active = 0;
    wbuf_en = 0; stop_gap_req = 0; dma_bnd = 0; data_tout = 0;
    clr_we = 0; clr_data = '0; sig_en = '1;
    cur_req = "R11"; ticks(3);
    expect_bit(0, 0); expect_bit(3, 0);
    rst_n = 1; tick();

    cur_req = "R1";
    wbuf_en = 1; tick(); expect_bit(3, 1);
    clear(5'b01000); ticks(3); expect_bit(3, 0);
    wbuf_en = 0; tick(); wbuf_en = 1; tick(); expect_bit(3, 1);
    clear(5'b01000); wbuf_en = 0; tick();

    cur_req = "R2";
    dir_wr = 0; dat_active = 1; rd_active = 1; tick();
    dat_active = 0; tick(); expect_bit(0, 0);
    rd_active = 0; tick(); expect_bit(0, 1);
    clear(5'b11111);

    cur_req = "R3";
    dir_wr = 1; dat_active = 1; rd_active = 1; wr_active = 1; tick();
    rd_active = 0; wr_active = 0; tick(); expect_bit(0, 0);
    dat_active = 0; tick(); expect_bit(0, 1);
    clear(5'b11111);

    cur_req = "R4";
    stop_gap_req = 0;
    dir_wr = 1; wr_active = 1; dat_active = 1; tick();
    wr_active = 0; dat_active = 0; tick(); expect_bit(1, 0);
    dir_wr = 0; dat_active = 1; tick(); dat_active = 0; tick(); expect_bit(1, 0);
    clear(5'b11111);

    cur_req = "R5";
    stop_gap_req = 1; dir_wr = 0;
    wr_active = 1; tick(); wr_active = 0; tick(); expect_bit(1, 0);
    dat_active = 1; tick(); dat_active = 0; tick(); expect_bit(1, 1);
    clear(5'b11111);
    dir_wr = 1; dat_active = 1; wr_active = 1; tick();
    wr_active = 0; tick(); expect_bit(1, 1);
    dat_active = 0; tick(); clear(5'b11111);
    stop_gap_req = 0;

    cur_req = "R6";
    dir_wr = 0; dma_bnd = 1; tick(); expect_bit(2, 1);
    clear(5'b00100);
    rd_active = 1; tick(); rd_active = 0; dma_bnd = 1; tick();
    expect_bit(0, 1); expect_bit(2, 0);
    dma_bnd = 1; tick(); expect_bit(2, 0);
    clear(5'b11111);

    cur_req = "R7";
    data_tout = 1; tick(); expect_bit(4, 1);
    cur_req = "R9";
    cmp("failed while timeout only", xfer_failed, 1);
    rd_active = 1; tick(); rd_active = 0; tick();
    cmp("failed after done", xfer_failed, 0);
    data_tout = 0; clear(5'b11111);

    cur_req = "R8";
    wbuf_en = 1; tick();
    clr_we = 1; clr_data = 5'b00000; tick(); expect_bit(3, 1);
    clr_we = 0; clr_data = 5'b01000; tick(); expect_bit(3, 1);
    wbuf_en = 0; tick(); wbuf_en = 1; clr_we = 1; clr_data = 5'b01000; tick();
    expect_bit(3, 1);
    clear(5'b11111); wbuf_en = 0; tick();

    cur_req = "R10";
    sig_en = 5'b00000; data_tout = 1; tick();
    expect_bit(4, 1); cmp("irq masked", irq, 0);
    sig_en = 5'b10000; tick(); cmp("irq enabled", irq, 1);
    sig_en = 5'b01111; tick(); cmp("irq other enables", irq, 0);
    sig_en = '1; data_tout = 0; clear(5'b11111);

    cur_req = "R11";
    wbuf_en = 1; tick(); rst_n = 0; tick(); cmp("status in reset", status, 0);
    rst_n = 1; tick(); expect_bit(3, 1);
    clear(5'b11111); wbuf_en = 0; tick();

    cur_req = "R8";
    for (int k = 0; k < 2000; k++) begin
      int r = $urandom;
      dir_wr = r[0]; dat_active = r[1]; rd_active = r[2]; wr_active = r[3];
      wbuf_en = r[4]; stop_gap_req = r[5]; dma_bnd = (r[8:6] == 0);
      data_tout = r[9] & r[10]; clr_we = (r[13:11] == 0);
      clr_data = r[18:14]; sig_en = r[23:19];
      rst_n = (r[31:24] != 0);
      tick();
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule